// File: doc/BRIEF.md
# Triggered Event Memory with Crossing Tags

This block holds the results of up to sixteen triggered events for a 36-channel front-end. When a trigger is accepted, the block opens a new event row. The row records the 24-bit bunch-crossing stamp of that trigger and the 36-bit pattern of channels that fired. Conversion results then arrive one channel at a time and are written into the newest row. Each result is a 12-bit Gray-coded value plus a gain-select bit. Once all sixteen rows are taken, a full flag tells the acquisition logic to stop.

The readout controller sees the event count and pulls rows out through a valid/ready stream, oldest row first. A row is offered while out_valid is high. It stays offered, unchanged, until out_ready is high at a rising edge. When out_ready is low, the same row is held. The trigger side is also valid/ready: trig_ready drops while the memory is full or while the clear strobe is high, and a trigger offered without ready is discarded, not queued. Conversion writes are accepted whenever conv_ready is high. After the transfer, the controller pulses rd_done, which empties the memory.

Top module: `event_tag_memory`

## Requirements
- R1: After reset, evt_count is 0, mem_full is 0, out_valid is 0 and trig_ready is 1.
- R2: A trigger is accepted when trig_valid and trig_ready are both high at a rising edge. The stamp and hit pattern go into row number evt_count (rows numbered from 0), and evt_count rises by one at that edge.
- R3: mem_full is 1 exactly when evt_count is 16, and trig_ready is then 0. A trigger offered while full changes neither the count nor any stored row.
- R4: conv_ready is 1 whenever evt_count is nonzero. A write with conv_valid and conv_ready high stores {conv_gain, conv_code} into channel conv_chan of row evt_count-1, overwriting any earlier value there.
- R5: A conversion write whose conv_chan is 36 or above is ignored, and so is any conversion offered while evt_count is 0.
- R6: Every cell of a newly accepted row reads as 0 (gain 0, code 0) until a conversion writes it.
- R7: out_valid is 1 while fewer rows have been transferred than evt_count. The offered row is the oldest untransferred one. A handshake (out_valid and out_ready high) moves to the next row. out_last marks the newest row. Transferring rows does not change evt_count.
- R8: rd_done resets the count and the read position to 0 at the next edge. It has priority over a trigger in the same cycle: trig_ready is 0 while rd_done is 1.
- R9: With evt_count 0, out_valid is 0, so a controller that sees a zero count skips the transfer.
- R10: In out_cells, channel c takes bits [13c+12:13c]. Bit 13c+12 is the gain flag and the lower 12 bits are the Gray code, passed through without change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_valid | input | 1 | Trigger offered |
| trig_ready | output | 1 | Trigger can be accepted |
| trig_bcid | input | 24 | Bunch-crossing stamp of the trigger |
| trig_hits | input | 36 | Channels that fired |
| conv_valid | input | 1 | Conversion result offered |
| conv_ready | output | 1 | An open row exists |
| conv_chan | input | 6 | Channel index of the result |
| conv_code | input | 12 | Gray-coded converted value |
| conv_gain | input | 1 | Gain select of the result |
| out_valid | output | 1 | Row offered to readout |
| out_ready | input | 1 | Readout takes the offered row |
| out_bcid | output | 24 | Stamp of the offered row |
| out_hits | output | 36 | Hit pattern of the offered row |
| out_cells | output | 468 | All channel cells of the offered row |
| out_last | output | 1 | Offered row is the newest one |
| rd_done | input | 1 | Readout finished; empty the memory |
| mem_full | output | 1 | All rows in use |
| evt_count | output | 5 | Stored event count |

## Verification
The bench fills the memory and keeps triggering past sixteen. A design that wrapped its row index would overwrite row 0 and show a wrong first stamp; one that kept counting would report 17 or clear the full flag. Conversions arrive in the same cycle as a new trigger, at out-of-range channel numbers, and with an empty memory. These cases catch a write aimed at the new row instead of the previous one, a write to a phantom channel, and a write to row 15 after an empty-count underflow. rd_done is pulsed together with a trigger and during a stalled transfer. This exposes a clear that loses priority or leaves the read position behind, and stale cells from an earlier fill that show through in a reused row.

// File: rtl/evm_pkg.sv
package evm_pkg;
  localparam int unsigned EVM_ROWS  = 16;
  localparam int unsigned EVM_CHANS = 36;
  localparam int unsigned EVM_VAL_W = 12;
  localparam int unsigned EVM_TAG_W = 24;

  // gain flag sits above the Gray code in every stored cell
  function automatic int unsigned cell_width(input int unsigned val_w);
    return val_w + 1;
  endfunction
endpackage

// File: rtl/evm_ctrl.sv
module evm_ctrl #(
  parameter int unsigned ROWS = evm_pkg::EVM_ROWS,
  localparam int unsigned CNT_W = $clog2(ROWS + 1),
  localparam int unsigned ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_valid,
  input  logic             conv_valid,
  input  logic             chan_ok,
  input  logic             out_ready,
  input  logic             rd_done,
  output logic             trig_ready,
  output logic             trig_acc,
  output logic             conv_ready,
  output logic             conv_acc,
  output logic             out_valid,
  output logic             out_last,
  output logic             full,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] rd_ptr,
  output logic [ROW_W-1:0] new_row,
  output logic [ROW_W-1:0] last_row
);
  logic [CNT_W-1:0] last_full;

  assign full       = (count == CNT_W'(ROWS));
  assign trig_ready = !full && !rd_done;
  assign trig_acc   = trig_valid && trig_ready;
  assign conv_ready = (count != '0);
  assign conv_acc   = conv_valid && conv_ready && chan_ok;
  assign out_valid  = (rd_ptr < count);
  assign last_full  = count - CNT_W'(1);
  assign out_last   = out_valid && (rd_ptr == last_full);
  assign new_row    = count[ROW_W-1:0];
  assign last_row   = last_full[ROW_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      rd_ptr <= '0;
    end else if (rd_done) begin
      count  <= '0;
      rd_ptr <= '0;
    end else begin
      count  <= count + CNT_W'(trig_acc);
      rd_ptr <= rd_ptr + CNT_W'(out_valid && out_ready);
    end
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(ROWS));
  assert_full_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_done) |=> (count == $past(count)));
  assert_trig_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && trig_ready) |=> (count == $past(count) + CNT_W'(1)));
  assert_done_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> (count == '0 && rd_ptr == '0));
  assert_ptr_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr <= count);
  assert_empty_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !out_valid);
endmodule

// File: rtl/evm_tag_store.sv
module evm_tag_store #(
  parameter int unsigned ROWS  = evm_pkg::EVM_ROWS,
  parameter int unsigned CHANS = evm_pkg::EVM_CHANS,
  parameter int unsigned TAG_W = evm_pkg::EVM_TAG_W,
  localparam int unsigned ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [CHANS-1:0] wr_hits,
  input  logic [ROW_W-1:0] rd_row,
  output logic [TAG_W-1:0] rd_tag,
  output logic [CHANS-1:0] rd_hits
);
  logic [TAG_W-1:0] tag_q [ROWS];
  logic [CHANS-1:0] hit_q [ROWS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < int'(ROWS); r++) begin
        tag_q[r] <= '0;
        hit_q[r] <= '0;
      end
    end else if (wr_en) begin
      tag_q[wr_row] <= wr_tag;
      hit_q[wr_row] <= wr_hits;
    end
  end

  assign rd_tag  = tag_q[rd_row];
  assign rd_hits = hit_q[rd_row];
endmodule

// File: rtl/evm_value_store.sv
module evm_value_store #(
  parameter int unsigned ROWS  = evm_pkg::EVM_ROWS,
  parameter int unsigned CHANS = evm_pkg::EVM_CHANS,
  parameter int unsigned VAL_W = evm_pkg::EVM_VAL_W,
  localparam int unsigned ROW_W  = $clog2(ROWS),
  localparam int unsigned CHAN_W = $clog2(CHANS),
  localparam int unsigned CELL_W = evm_pkg::cell_width(VAL_W)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_en,
  input  logic [ROW_W-1:0]        clr_row,
  input  logic                    wr_en,
  input  logic [ROW_W-1:0]        wr_row,
  input  logic [CHAN_W-1:0]       wr_chan,
  input  logic [CELL_W-1:0]       wr_cell,
  input  logic [ROW_W-1:0]        rd_row,
  output logic [CHANS*CELL_W-1:0] rd_cells
);
  logic [CELL_W-1:0] cell_q [ROWS][CHANS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < int'(ROWS); r++)
        for (int c = 0; c < int'(CHANS); c++)
          cell_q[r][c] <= '0;
    end else begin
      if (clr_en)
        for (int c = 0; c < int'(CHANS); c++)
          cell_q[clr_row][c] <= '0;
      if (wr_en)
        cell_q[wr_row][wr_chan] <= wr_cell;
    end
  end

  for (genvar c = 0; c < int'(CHANS); c++) begin : g_rd
    assign rd_cells[c*CELL_W +: CELL_W] = cell_q[rd_row][c];
  end

  // the row being opened and the row being filled must never coincide
  assert_no_clash_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_en && wr_en && (clr_row == wr_row)));
endmodule

// File: rtl/event_tag_memory.sv
module event_tag_memory #(
  parameter int unsigned ROWS  = evm_pkg::EVM_ROWS,
  parameter int unsigned CHANS = evm_pkg::EVM_CHANS,
  parameter int unsigned VAL_W = evm_pkg::EVM_VAL_W,
  parameter int unsigned TAG_W = evm_pkg::EVM_TAG_W,
  localparam int unsigned CNT_W  = $clog2(ROWS + 1),
  localparam int unsigned ROW_W  = $clog2(ROWS),
  localparam int unsigned CHAN_W = $clog2(CHANS),
  localparam int unsigned CELL_W = evm_pkg::cell_width(VAL_W)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    trig_valid,
  output logic                    trig_ready,
  input  logic [TAG_W-1:0]        trig_bcid,
  input  logic [CHANS-1:0]        trig_hits,
  input  logic                    conv_valid,
  output logic                    conv_ready,
  input  logic [CHAN_W-1:0]       conv_chan,
  input  logic [VAL_W-1:0]        conv_code,
  input  logic                    conv_gain,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [TAG_W-1:0]        out_bcid,
  output logic [CHANS-1:0]        out_hits,
  output logic [CHANS*CELL_W-1:0] out_cells,
  output logic                    out_last,
  input  logic                    rd_done,
  output logic                    mem_full,
  output logic [CNT_W-1:0]        evt_count
);
  logic             chan_ok, trig_acc, conv_acc;
  logic [CNT_W-1:0] rd_ptr;
  logic [ROW_W-1:0] new_row, last_row;

  assign chan_ok = ({1'b0, conv_chan} < (CHAN_W + 1)'(CHANS));

  evm_ctrl #(.ROWS(ROWS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .conv_valid(conv_valid),
    .chan_ok(chan_ok), .out_ready(out_ready), .rd_done(rd_done),
    .trig_ready(trig_ready), .trig_acc(trig_acc), .conv_ready(conv_ready),
    .conv_acc(conv_acc), .out_valid(out_valid), .out_last(out_last),
    .full(mem_full), .count(evt_count), .rd_ptr(rd_ptr),
    .new_row(new_row), .last_row(last_row)
  );

  evm_tag_store #(.ROWS(ROWS), .CHANS(CHANS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .wr_en(trig_acc), .wr_row(new_row),
    .wr_tag(trig_bcid), .wr_hits(trig_hits), .rd_row(rd_ptr[ROW_W-1:0]),
    .rd_tag(out_bcid), .rd_hits(out_hits)
  );

  evm_value_store #(.ROWS(ROWS), .CHANS(CHANS), .VAL_W(VAL_W)) u_vals (
    .clk(clk), .rst_n(rst_n), .clr_en(trig_acc), .clr_row(new_row),
    .wr_en(conv_acc), .wr_row(last_row), .wr_chan(conv_chan),
    .wr_cell({conv_gain, conv_code}), .rd_row(rd_ptr[ROW_W-1:0]),
    .rd_cells(out_cells)
  );

  assert_full_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_full |-> !trig_ready);
  assert_bad_chan_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && !chan_ok) |-> !conv_acc);
  assert_hold_row_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !rd_done && !conv_valid) |=>
      ($stable(out_bcid) && $stable(out_hits)));
endmodule

// File: tb/event_tag_memory_bench.sv
module event_tag_memory_bench;
  localparam int ROWS = 16, CHANS = 36, CW = 13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic trig_valid = 0, conv_valid = 0, conv_gain = 0, out_ready = 0, rd_done = 0;
  logic [23:0] trig_bcid = '0;
  logic [35:0] trig_hits = '0;
  logic [5:0]  conv_chan = '0;
  logic [11:0] conv_code = '0;
  logic trig_ready, conv_ready, out_valid, out_last, mem_full;
  logic [23:0] out_bcid;
  logic [35:0] out_hits;
  logic [CHANS*CW-1:0] out_cells;
  logic [4:0] evt_count;

  event_tag_memory u_event_tag_memory (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_ready(trig_ready),
    .trig_bcid(trig_bcid), .trig_hits(trig_hits), .conv_valid(conv_valid),
    .conv_ready(conv_ready), .conv_chan(conv_chan), .conv_code(conv_code),
    .conv_gain(conv_gain), .out_valid(out_valid), .out_ready(out_ready),
    .out_bcid(out_bcid), .out_hits(out_hits), .out_cells(out_cells),
    .out_last(out_last), .rd_done(rd_done), .mem_full(mem_full),
    .evt_count(evt_count)
  );

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0, n_cyc = 0;
  bit finished = 0;

  // behavioural reference
  int mcount = 0, mptr = 0;
  logic [23:0] m_bcid [ROWS];
  logic [35:0] m_hits [ROWS];
  logic [CW-1:0] m_cell [ROWS][CHANS];
  bit tr_ok, cv_ok, rd_ok;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcount = 0; mptr = 0;
    end else begin
      tr_ok = trig_valid && !rd_done && mcount < ROWS;
      cv_ok = conv_valid && mcount != 0 && conv_chan < CHANS;
      rd_ok = out_ready && mptr < mcount;
      if (cv_ok) m_cell[mcount-1][conv_chan] = {conv_gain, conv_code};
      if (rd_done) begin
        mcount = 0; mptr = 0;
      end else begin
        if (rd_ok) mptr++;
        if (tr_ok) begin
          m_bcid[mcount] = trig_bcid;
          m_hits[mcount] = trig_hits;
          for (int c = 0; c < CHANS; c++) m_cell[mcount][c] = '0;
          mcount++;
        end
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk("R2 R9", "evt_count", 64'(evt_count), 64'(mcount));
      chk("R3", "mem_full", 64'(mem_full), 64'(mcount == ROWS));
      chk("R3 R8", "trig_ready", 64'(trig_ready), 64'(mcount < ROWS && !rd_done));
      chk("R4", "conv_ready", 64'(conv_ready), 64'(mcount != 0));
      chk("R7 R9", "out_valid", 64'(out_valid), 64'(mptr < mcount));
      chk("R7", "out_last", 64'(out_last), 64'(mptr < mcount && mptr == mcount - 1));
      if (mptr < mcount) begin
        chk("R2 R7", "out_bcid", 64'(out_bcid), 64'(m_bcid[mptr]));
        chk("R2 R7", "out_hits", 64'(out_hits), 64'(m_hits[mptr]));
        for (int c = 0; c < CHANS; c++)
          chk("R4 R5 R6 R10", "cell", 64'(out_cells[c*CW +: CW]), 64'(m_cell[mptr][c]));
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic idle();
    trig_valid = 0; conv_valid = 0; out_ready = 0; rd_done = 0;
  endtask

  task automatic trig(input logic [23:0] b, input logic [35:0] h);
    trig_valid = 1; trig_bcid = b; trig_hits = h;
  endtask

  task automatic conv(input int ch, input int code, input bit g);
    conv_valid = 1; conv_chan = 6'(ch); conv_code = 12'(code); conv_gain = g;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 150000 && !finished) begin
      finished = 1; n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=below 150000", n_cyc);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    // R1: reset values, sampled while reset is still held
    chk("R1", "count in reset", 64'(evt_count), 64'd0);
    chk("R1", "full in reset", 64'(mem_full), 64'd0);
    chk("R1", "valid in reset", 64'(out_valid), 64'd0);
    chk("R1", "ready in reset", 64'(trig_ready), 64'd1);
    rst_n = 1; cyc();
    // R5: conversion offered with an empty memory is dropped
    conv(3, 12'h555, 1); cyc(); idle();
    chk("R9", "empty count", 64'(evt_count), 64'd0);
    trig(24'hABCDEF, 36'h0_0000_0009); cyc(); idle();
    chk("R2", "count after first", 64'(evt_count), 64'd1);
    conv(0, 12'h123, 1); cyc();
    conv(35, 12'hFED, 0); cyc();
    conv(40, 12'h777, 1); cyc(); // R5: out-of-range channel
    conv(17, 12'h111, 0); cyc();
    conv(17, 12'h222, 1); cyc(); // R4: overwrite
    // conversion in the same cycle as the next trigger targets the older row
    trig(24'h000100, 36'hF_0000_0000); conv(5, 12'h0AA, 1); cyc(); idle();
    trig(24'h000200, 36'h0_FFFF_0000); cyc(); idle();
    out_ready = 1; cyc(); out_ready = 0; cyc(); out_ready = 1; cyc(); idle();
    // fill past capacity (R3)
    for (int i = 0; i < 18; i++) begin
      trig(24'(32'h1000 + i), 36'(i * 7 + 1)); conv(i, i * 13, i[0]); cyc();
    end
    idle();
    chk("R3", "full after overfill", 64'(mem_full), 64'd1);
    chk("R3", "count after overfill", 64'(evt_count), 64'd16);
    for (int i = 0; i < 40; i++) begin
      out_ready = ($urandom % 3) != 0; cyc();
    end
    idle();
    // R8: clear wins over a coincident trigger
    trig(24'h0DEAD0, 36'h1); rd_done = 1; cyc(); idle();
    chk("R8", "count after clear", 64'(evt_count), 64'd0);
    chk("R9", "valid after clear", 64'(out_valid), 64'd0);
    trig(24'h0C0FFE, 36'h3); cyc(); idle();
    out_ready = 1; cyc();
    rd_done = 1; cyc(); idle();
    for (int i = 0; i < 600; i++) begin
      trig_valid = ($urandom % 3) == 0;
      trig_bcid = 24'($urandom); trig_hits = {4'($urandom), 32'($urandom)};
      conv_valid = ($urandom % 2) == 0;
      conv_chan = 6'($urandom % 40); conv_code = 12'($urandom); conv_gain = 1'($urandom);
      out_ready = ($urandom % 2) == 0;
      rd_done = ($urandom % 60) == 0;
      cyc();
    end
    idle(); cyc(); cyc();
    finished = 1;
    summary();
    $finish;
  end
endmodule